// File: doc/BRIEF.md
# Register Frame Call/Return Engine

This block manages a register file that is split into fixed 16-entry frames and takes care of the frame bookkeeping for procedure calls. It holds three frame pointers. The current frame holds the running procedure's arguments and locals. The staged frame is being filled with arguments for the next call. The result frame is the one the last finished callee used. Each cycle the engine accepts one command: stage, call, return, tail-stage or tail-call. It updates the pointers in that same clock.

Frame numbers that are not in use sit in a hardware free list. This list is first-in first-out, not a stack. Because of that, a tail call can give its frame back at any time. Saved frame pointer pairs and saved return PC/destination pairs are kept on two hidden stacks that software never addresses. The engine also turns short instruction register addresses into physical register-file addresses. Each read port has its own translator, and a per-instruction selector picks which global frame is visible. When the free list is nearly empty, a level output tells software to spill frames to memory.

Top module: `frame_call_engine`

## Requirements
- R1: After reset the current frame is 16, the staged frame is 17, the result frame is 18, the free count is 237, and every error and resume output is low.
- R2: A 6-bit register address is split as {class[5:4], offset[3:0]}. Class 0 selects global frame `gsel_i`, class 1 the current frame, class 2 the staged frame and class 3 the result frame. The physical address is {frame[7:0], offset}, and it follows the inputs combinationally.
- R3: Command 1 (stage) saves the {staged, current} pair on the hidden frame stack, sets the staged frame to the oldest entry of the free list, and lowers the free count by one. Stages may nest.
- R4: Command 2 (call) saves {ret_pc_i, ret_dest_i} on the hidden link stack and copies the staged frame into the current frame. The staged frame keeps its value.
- R5: Command 3 (return) appends the old result frame to the tail of the free list and moves the current frame into the result frame. It restores staged and current from the frame stack, and drives the saved PC and destination on the resume outputs with a one-cycle valid pulse.
- R6: Command 4 (tail-stage) takes a new staged frame from the free list and saves nothing on the frame stack.
- R7: Command 5 (tail-call) appends the current frame to the tail of the free list at once and copies the staged frame into the current frame.
- R8: A return accepted in one cycle followed by a return in the next cycle makes the engine ignore the second one and pulse `err_seq_o`.
- R9: `low_water_o` is high exactly when the free count is at or below LOW_WATER (4).
- R10: A command whose resource is missing is ignored and `err_res_o` pulses. This covers a stage or tail-stage on an empty free list, a call with the link stack full, a stage with the frame stack full, and a return with either stack empty.
- R11: Command 0 (no-op) and any unused code leave every pointer and the free count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code, sampled each cycle |
| ret_pc_i | input | 16 | Return PC saved by a call |
| ret_dest_i | input | 6 | Return destination register address saved by a call |
| gsel_i | input | 4 | Visible global frame selector |
| raddr_i | input | 18 | Three packed 6-bit register addresses, port 0 in the low bits |
| paddr_o | output | 36 | Three packed 12-bit physical addresses |
| active_o | output | 8 | Current frame number |
| open_o | output | 8 | Staged frame number |
| return_o | output | 8 | Result frame number |
| free_count_o | output | 9 | Number of frames in the free list |
| low_water_o | output | 1 | Free list at or below threshold |
| resume_valid_o | output | 1 | One-cycle pulse after an accepted return |
| resume_pc_o | output | 16 | PC restored by the last return |
| resume_dest_o | output | 6 | Destination restored by the last return |
| err_seq_o | output | 1 | Pulse when a back-to-back return is rejected |
| err_res_o | output | 1 | Pulse when a command lacks its resource |

## Verification
Nested stages followed by call and return show whether the frame pairs come back in stack order, and whether the freed result frame goes to the tail rather than being reused at once. A tail-stage plus tail-call followed by a plain return shows that the tail path pushes no continuation: the return must restore the pair saved by the very first stage. A long run of tail-stages drains the free list through the low-water threshold down to empty. It checks the FIFO reuse order of the freed frames and the threshold edge, and it ends with the empty-list rejection. A return issued twice in a row, and a return on empty stacks, are each checked for the right error pulse with the state held still.

// File: rtl/fce_pkg.sv
package fce_pkg;
   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_OPEN  = 3'd1,
      CMD_CALL  = 3'd2,
      CMD_RET   = 3'd3,
      CMD_TOPEN = 3'd4,
      CMD_TCALL = 3'd5
   } cmd_e;

   typedef enum logic [1:0] {
      CLS_GLOBAL = 2'd0,
      CLS_ACTIVE = 2'd1,
      CLS_OPEN   = 2'd2,
      CLS_RETURN = 2'd3
   } cls_e;

   localparam int RADDR_W = 6;
   localparam int OFS_W   = 4;
endpackage

// File: rtl/fce_freelist.sv
module fce_freelist #(
   parameter int W        = 8,
   parameter int DEPTH    = 256,
   parameter int FIRST    = 19,
   parameter int INIT_CNT = 237,
   localparam int PTR_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     push_val,
   input  logic             pop,
   output logic [W-1:0]     head,
   output logic [CNT_W-1:0] count,
   output logic             empty
);
   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rd_q, wr_q;

   if ((1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("free list depth must be a power of two");
   end
   if (INIT_CNT > DEPTH) begin : g_bad_init
      $error("initial free count exceeds depth");
   end

   assign head  = mem[rd_q];
   assign empty = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= PTR_W'(INIT_CNT);
         count <= CNT_W'(INIT_CNT);
         for (int i = 0; i < DEPTH; i++) mem[i] <= W'(FIRST + i);
      end else begin
         if (push) begin
            mem[wr_q] <= push_val;
            wr_q      <= wr_q + 1'b1;
         end
         if (pop) rd_q <= rd_q + 1'b1;
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end
endmodule

// File: rtl/fce_stack.sv
module fce_stack #(
   parameter int W     = 16,
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int SP_W  = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_val,
   input  logic         pop,
   output logic [W-1:0] top,
   output logic         empty,
   output logic         full
);
   logic [W-1:0]    mem [DEPTH];
   logic [SP_W-1:0] sp_q;

   assign top   = mem[IDX_W'(sp_q - SP_W'(1))];
   assign empty = (sp_q == '0);
   assign full  = (sp_q == SP_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q <= '0;
      end else if (push) begin
         mem[IDX_W'(sp_q)] <= push_val;
         sp_q              <= sp_q + 1'b1;
      end else if (pop) begin
         sp_q <= sp_q - 1'b1;
      end
   end
endmodule

// File: rtl/fce_xlate.sv
module fce_xlate
   import fce_pkg::*;
#(
   parameter int FRAME_W = 8,
   parameter int GSEL_W  = 4
) (
   input  logic [RADDR_W-1:0]       raddr,
   input  logic [GSEL_W-1:0]        gsel,
   input  logic [FRAME_W-1:0]       act_frame,
   input  logic [FRAME_W-1:0]       opn_frame,
   input  logic [FRAME_W-1:0]       ret_frame,
   output logic [FRAME_W+OFS_W-1:0] paddr
);
   logic [FRAME_W-1:0] frame;

   always_comb begin
      unique case (cls_e'(raddr[RADDR_W-1:OFS_W]))
         CLS_GLOBAL: frame = FRAME_W'(gsel);
         CLS_ACTIVE: frame = act_frame;
         CLS_OPEN:   frame = opn_frame;
         default:    frame = ret_frame;
      endcase
   end

   assign paddr = {frame, raddr[OFS_W-1:0]};
endmodule

// File: rtl/frame_call_engine.sv
module frame_call_engine
   import fce_pkg::*;
#(
   parameter int FRAME_W     = 8,
   parameter int GSEL_W      = 4,
   parameter int PC_W        = 16,
   parameter int STACK_DEPTH = 16,
   parameter int LOW_WATER   = 4,
   parameter int NUM_PORTS   = 3,
   localparam int NUM_FRAMES = 1 << FRAME_W,
   localparam int NUM_GLOBAL = 1 << GSEL_W,
   localparam int INIT_CNT   = NUM_FRAMES - NUM_GLOBAL - 3,
   localparam int CNT_W      = $clog2(NUM_FRAMES + 1),
   localparam int PADDR_W    = FRAME_W + OFS_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [2:0]                   cmd_i,
   input  logic [PC_W-1:0]              ret_pc_i,
   input  logic [RADDR_W-1:0]           ret_dest_i,
   input  logic [GSEL_W-1:0]            gsel_i,
   input  logic [NUM_PORTS*RADDR_W-1:0] raddr_i,
   output logic [NUM_PORTS*PADDR_W-1:0] paddr_o,
   output logic [FRAME_W-1:0]           active_o,
   output logic [FRAME_W-1:0]           open_o,
   output logic [FRAME_W-1:0]           return_o,
   output logic [CNT_W-1:0]             free_count_o,
   output logic                         low_water_o,
   output logic                         resume_valid_o,
   output logic [PC_W-1:0]              resume_pc_o,
   output logic [RADDR_W-1:0]           resume_dest_o,
   output logic                         err_seq_o,
   output logic                         err_res_o
);
   if (NUM_GLOBAL + 3 >= NUM_FRAMES) begin : g_bad_frames
      $error("too few frames beyond the global ones");
   end
   if (LOW_WATER >= INIT_CNT) begin : g_bad_lw
      $error("low-water threshold must be below the initial free count");
   end

   cmd_e cmd;
   logic [FRAME_W-1:0] act_q, opn_q, ret_q;
   logic last_ret_q;
   logic seq_bad, res_bad, go;
   logic do_open, do_call, do_ret, do_topen, do_tcall;

   logic               fl_push, fl_pop, fl_empty;
   logic [FRAME_W-1:0] fl_push_val, fl_head;

   logic                   fs_full, fs_empty, ls_full, ls_empty;
   logic [2*FRAME_W-1:0]   fs_top;
   logic [PC_W+RADDR_W-1:0] ls_top;

   assign cmd = cmd_e'(cmd_i);

   always_comb begin
      seq_bad = (cmd == CMD_RET) && last_ret_q;
      unique case (cmd)
         CMD_OPEN:  res_bad = fl_empty || fs_full;
         CMD_CALL:  res_bad = ls_full;
         CMD_RET:   res_bad = fs_empty || ls_empty;
         CMD_TOPEN: res_bad = fl_empty;
         default:   res_bad = 1'b0;
      endcase
   end

   assign go       = !seq_bad && !res_bad;
   assign do_open  = go && (cmd == CMD_OPEN);
   assign do_call  = go && (cmd == CMD_CALL);
   assign do_ret   = go && (cmd == CMD_RET);
   assign do_topen = go && (cmd == CMD_TOPEN);
   assign do_tcall = go && (cmd == CMD_TCALL);

   assign fl_pop      = do_open || do_topen;
   assign fl_push     = do_ret || do_tcall;
   assign fl_push_val = do_ret ? ret_q : act_q;

   fce_freelist #(
      .W(FRAME_W), .DEPTH(NUM_FRAMES), .FIRST(NUM_GLOBAL + 3), .INIT_CNT(INIT_CNT)
   ) u_free (
      .clk(clk), .rst_n(rst_n), .push(fl_push), .push_val(fl_push_val),
      .pop(fl_pop), .head(fl_head), .count(free_count_o), .empty(fl_empty)
   );

   fce_stack #(.W(2*FRAME_W), .DEPTH(STACK_DEPTH)) u_frame_stk (
      .clk(clk), .rst_n(rst_n), .push(do_open), .push_val({opn_q, act_q}),
      .pop(do_ret), .top(fs_top), .empty(fs_empty), .full(fs_full)
   );

   fce_stack #(.W(PC_W+RADDR_W), .DEPTH(STACK_DEPTH)) u_link_stk (
      .clk(clk), .rst_n(rst_n), .push(do_call), .push_val({ret_pc_i, ret_dest_i}),
      .pop(do_ret), .top(ls_top), .empty(ls_empty), .full(ls_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q          <= FRAME_W'(NUM_GLOBAL);
         opn_q          <= FRAME_W'(NUM_GLOBAL + 1);
         ret_q          <= FRAME_W'(NUM_GLOBAL + 2);
         last_ret_q     <= 1'b0;
         resume_valid_o <= 1'b0;
         resume_pc_o    <= '0;
         resume_dest_o  <= '0;
         err_seq_o      <= 1'b0;
         err_res_o      <= 1'b0;
      end else begin
         if (do_open || do_topen) opn_q <= fl_head;
         if (do_call || do_tcall) act_q <= opn_q;
         if (do_ret) begin
            ret_q                         <= act_q;
            {opn_q, act_q}                <= fs_top;
            {resume_pc_o, resume_dest_o}  <= ls_top;
         end
         last_ret_q     <= do_ret;
         resume_valid_o <= do_ret;
         err_seq_o      <= seq_bad;
         err_res_o      <= res_bad && !seq_bad;
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      fce_xlate #(.FRAME_W(FRAME_W), .GSEL_W(GSEL_W)) u_xlate (
         .raddr    (raddr_i[p*RADDR_W +: RADDR_W]),
         .gsel     (gsel_i),
         .act_frame(act_q),
         .opn_frame(opn_q),
         .ret_frame(ret_q),
         .paddr    (paddr_o[p*PADDR_W +: PADDR_W])
      );
   end

   assign active_o    = act_q;
   assign open_o      = opn_q;
   assign return_o    = ret_q;
   assign low_water_o = (free_count_o <= CNT_W'(LOW_WATER));
endmodule

// File: rtl/fce_checker.sv
module fce_checker #(
   parameter int FRAME_W = 8,
   parameter int CNT_W   = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         cmd_i,
   input logic [FRAME_W-1:0] active_o,
   input logic [FRAME_W-1:0] open_o,
   input logic [FRAME_W-1:0] return_o,
   input logic [CNT_W-1:0]   free_count_o,
   input logic               resume_valid_o,
   input logic               err_seq_o,
   input logic               err_res_o
);
   // R3: the free count moves by at most one frame per cycle
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (free_count_o == $past(free_count_o)) ||
               (free_count_o == $past(free_count_o) + 1'b1) ||
               (free_count_o + 1'b1 == $past(free_count_o)));

   a_r4_call_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd2) |=> err_res_o || (active_o == $past(open_o)));

   a_r5_return_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd3) |=> err_seq_o || err_res_o ||
                          (return_o == $past(active_o) && resume_valid_o));

   a_r7_tail_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd5) |=> (active_o == $past(open_o)) &&
                          (free_count_o == $past(free_count_o) + 1'b1));

   a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (resume_valid_o && cmd_i == 3'd3) |=> err_seq_o && !resume_valid_o);

   a_r10_one_error: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_seq_o && err_res_o));

   a_r11_nop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == 3'd0) |=> $stable(active_o) && $stable(open_o) &&
                          $stable(return_o) && $stable(free_count_o));
endmodule

bind frame_call_engine fce_checker #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_fce_chk (
   .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .active_o(active_o), .open_o(open_o),
   .return_o(return_o), .free_count_o(free_count_o), .resume_valid_o(resume_valid_o),
   .err_seq_o(err_seq_o), .err_res_o(err_res_o)
);

// File: tb/tb_frame_call_engine.sv
module tb_frame_call_engine;
   localparam int DEPTH = 16;
   localparam int LOW   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd_i = '0;
   logic [15:0] ret_pc_i = '0;
   logic [5:0]  ret_dest_i = '0;
   logic [3:0]  gsel_i = '0;
   logic [17:0] raddr_i = '0;
   logic [35:0] paddr_o;
   logic [7:0]  active_o, open_o, return_o;
   logic [8:0]  free_count_o;
   logic        low_water_o, resume_valid_o, err_seq_o, err_res_o;
   logic [15:0] resume_pc_o;
   logic [5:0]  resume_dest_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   frame_call_engine dut (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .ret_pc_i(ret_pc_i),
      .ret_dest_i(ret_dest_i), .gsel_i(gsel_i), .raddr_i(raddr_i), .paddr_o(paddr_o),
      .active_o(active_o), .open_o(open_o), .return_o(return_o),
      .free_count_o(free_count_o), .low_water_o(low_water_o),
      .resume_valid_o(resume_valid_o), .resume_pc_o(resume_pc_o),
      .resume_dest_o(resume_dest_o), .err_seq_o(err_seq_o), .err_res_o(err_res_o)
   );

   // reference model state
   int          m_fl[$];
   logic [15:0] m_fs[$];
   logic [21:0] m_ls[$];
   logic [7:0]  m_a = 8'd16, m_o = 8'd17, m_r = 8'd18;
   logic [15:0] m_pc = '0;
   logic [5:0]  m_dest = '0;
   logic        m_last_ret = 1'b0;

   // snapshot: a,o,r,count,rv,pc,dest,eseq,eres,low
   typedef logic [65:0] snap_t;
   snap_t exp_q[$];
   string tag_q[$];

   function automatic snap_t actual();
      return {active_o, open_o, return_o, free_count_o, resume_valid_o,
              resume_pc_o, resume_dest_o, err_seq_o, err_res_o, low_water_o};
   endfunction

   task automatic check(input string tag, input logic [65:0] act, input logic [65:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] c, input logic [15:0] pc,
                        input logic [5:0] d, input string tag);
      logic seq, res, rv;
      int   cnt;
      @(negedge clk);
      cmd_i = c; ret_pc_i = pc; ret_dest_i = d;
      seq = (c == 3'd3) && m_last_ret;
      case (c)
         3'd1:    res = (m_fl.size() == 0) || (m_fs.size() == DEPTH);
         3'd2:    res = (m_ls.size() == DEPTH);
         3'd3:    res = (m_fs.size() == 0) || (m_ls.size() == 0);
         3'd4:    res = (m_fl.size() == 0);
         default: res = 1'b0;
      endcase
      rv = 1'b0;
      if (!seq && !res) begin
         case (c)
            3'd1: begin m_fs.push_back({m_o, m_a}); m_o = 8'(m_fl.pop_front()); end
            3'd2: begin m_ls.push_back({pc, d}); m_a = m_o; end
            3'd3: begin
               m_fl.push_back(int'(m_r));
               m_r = m_a;
               {m_o, m_a} = m_fs.pop_back();
               {m_pc, m_dest} = m_ls.pop_back();
               rv = 1'b1;
            end
            3'd4: m_o = 8'(m_fl.pop_front());
            3'd5: begin m_fl.push_back(int'(m_a)); m_a = m_o; end
            default: ;
         endcase
      end
      m_last_ret = rv;
      cnt = m_fl.size();
      exp_q.push_back({m_a, m_o, m_r, 9'(cnt), rv, m_pc, m_dest, seq, res && !seq,
                       (cnt <= LOW)});
      tag_q.push_back(tag);
   endtask

   // monitor: compare each command's result after the edge that applies it
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), actual(), exp_q.pop_front());
   end

   task automatic xlate_check(input logic [3:0] g, input logic [17:0] ra,
                              input logic [35:0] exp, input string tag);
      @(negedge clk);
      gsel_i = g; raddr_i = ra;
      #1 check(tag, 66'(paddr_o), 66'(exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 19; i < 256; i++) m_fl.push_back(i);
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1 check("R1 reset state", actual(),
               {8'd16, 8'd17, 8'd18, 9'd237, 1'b0, 16'h0, 6'h0, 1'b0, 1'b0, 1'b0});

      // R2: port2={11,F} port1={01,7} port0={00,3}
      xlate_check(4'd5, {6'h3F, 6'h17, 6'h03}, {12'h12F, 12'h107, 12'h053}, "R2 translate reset");
      xlate_check(4'd9, {6'h20, 6'h2A, 6'h0C}, {12'h110, 12'h11A, 12'h09C}, "R2 translate open/global");

      issue(3'd1, 16'h0, 6'h0, "R3 open first");
      issue(3'd1, 16'h0, 6'h0, "R3 open nested");
      issue(3'd2, 16'h0100, 6'h21, "R4 call");
      issue(3'd3, 16'h0, 6'h0, "R5 return");
      issue(3'd3, 16'h0, 6'h0, "R8 back-to-back return");
      issue(3'd0, 16'h0, 6'h0, "R11 nop");
      issue(3'd6, 16'h0, 6'h0, "R11 unused code");
      issue(3'd2, 16'h0200, 6'h05, "R4 call second");
      issue(3'd4, 16'h0, 6'h0, "R6 tail open");
      issue(3'd5, 16'h0, 6'h0, "R7 tail call");
      issue(3'd3, 16'h0, 6'h0, "R6 R5 return restores first pair");
      issue(3'd0, 16'h0, 6'h0, "R11 nop spacer");
      issue(3'd3, 16'h0, 6'h0, "R10 return on empty stacks");
      issue(3'd0, 16'h0, 6'h0, "R11 nop after error");
      for (int k = 0; k < 237; k++) issue(3'd4, 16'h0, 6'h0, "R9 drain by tail open");
      issue(3'd4, 16'h0, 6'h0, "R10 tail open on empty list");
      issue(3'd1, 16'h0, 6'h0, "R10 open on empty list");
      issue(3'd5, 16'h0, 6'h0, "R7 tail call on empty list");
      issue(3'd0, 16'h0, 6'h0, "R11 final nop");
      @(negedge clk);
      xlate_check(4'd0, {6'h31, 6'h22, 6'h13},
                  {m_r, 4'h1, m_o, 4'h2, m_a, 4'h3}, "R2 translate after moves");
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule